// File: doc/BRIEF.md
# I2C Slave Read-Transfer Status Engine

This block is the slave side of a two-wire serial bus, limited to transfers in which a remote master reads from it. It watches the bus for a START followed by an address byte. When the seven address bits equal the configured own address and the direction bit requests a read, it acknowledges. It then shifts out bytes that a local host placed in its data register, most significant bit first. After every bus event that needs the host's attention, it posts a byte-wide status code and raises an interrupt flag. While the flag is up, the block keeps SCL low so that the master waits for the host.

The host sees three things: a data register, a control register and a status byte. The control register holds the flag-clear bit, the acknowledge-enable bit and the stop bit. If the host clears the flag with acknowledge-enable low, the byte just loaded is marked as the final one. A START or STOP that appears inside a byte or an acknowledge slot is reported as a bus error. The host recovers from it without any STOP being placed on the bus. A lost-arbitration pulse from a neighbouring master changes the code posted when the slave is next addressed.

Top module: `i2c_slave_tx`

## Requirements
- R1: A START, then the own 7-bit address with the direction bit 1, makes the slave pull SDA low in the ninth clock. After that clock ends, the flag is set and the status reads 0xA8.
- R2: If `arb_lost` pulsed since the slave was last addressed, the code posted on a read-address match is 0xB0 instead of 0xA8.
- R3: A byte sent after the host clears the flag goes out MSB first from the data register. If the master ACKs it and the byte was not the final one, the status is 0xB8 and the slave stays addressed.
- R4: A byte that the master NACKs posts 0xC0 and leaves the slave not addressed, with SDA released.
- R5: If the flag was cleared with acknowledge-enable (control bit 1) at 0, the byte is the final one. When the master ACKs it, the status is 0xC8. After the flag is cleared, further bytes read as 0xFF and raise no flag.
- R6: The status byte reads 0xF8 while the flag is clear. Every code has its three low bits at zero.
- R7: An address that differs, or a write direction bit, gets no acknowledge, raises no flag and leaves the status at 0xF8.
- R8: A START or STOP inside an address bit (after its first bit), a data bit or an acknowledge slot sets the flag with status 0x00, and SDA is released.
- R9: During a bus error, a control write with bit 2 (stop) and bit 0 (clear) both set returns the block to not-addressed. The stop bit then reads 0, the acknowledge-enable bit keeps the written value, and neither line is driven. A later transfer then completes normally.
- R10: SCL is held low on every cycle that follows a cycle with the flag set. It is released one cycle after the flag is cleared.
- R11: Control bit 0 is write-one-to-clear, and writing 0 there leaves the flag set. A data-register write (`wr_sel`=0) while the flag is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| own_addr | input | 7 | Slave address to match |
| arb_lost | input | 1 | One-cycle pulse: neighbouring master lost arbitration |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | 0 selects data register, 1 selects control |
| wr_data | input | 8 | Host write data; control: bit0 clear, bit1 ack-enable, bit2 stop |
| status_o | output | 8 | Status code, 0xF8 when flag clear |
| flag_o | output | 1 | Interrupt flag |
| ack_en_o | output | 1 | Acknowledge-enable bit |
| stop_o | output | 1 | Stop bit |

## Verification
The properties assume a master that changes SDA only while SCL is low, except at a deliberate START or STOP. They also assume the master does not drive the bus while the slave stretches the clock. The bench's master model therefore sets data a few cycles into the low phase, waits for SCL to read high before timing the high phase, and creates bus errors only by moving SDA during a high phase it has already observed. Host writes are one-cycle strokes issued between bus phases, so the host never clears the flag in the same cycle as a bus event.

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       arb_lost,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] status_o,
  output logic       flag_o,
  output logic       ack_en_o,
  output logic       stop_o
);

  localparam logic [7:0] C_ADDR = 8'hA8;
  localparam logic [7:0] C_ADDR_ARB = 8'hB0;
  localparam logic [7:0] C_ACKED = 8'hB8;
  localparam logic [7:0] C_NACKED = 8'hC0;
  localparam logic [7:0] C_FINAL = 8'hC8;
  localparam logic [7:0] C_NONE = 8'hF8;
  localparam logic [7:0] C_BERR = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WAIT, S_TX, S_MACK, S_BERR
  } state_t;

  logic [SYNC_STAGES-1:0] scl_s, sda_s;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
      sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_s[SYNC_STAGES-1];
      sda_d <= sda_s[SYNC_STAGES-1];
    end

  wire scl = scl_s[SYNC_STAGES-1];
  wire sda = sda_s[SYNC_STAGES-1];
  wire rise = scl & ~scl_d;
  wire fall = ~scl & scl_d;
  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c = scl & scl_d & ~sda_d & sda;

  state_t st;
  logic [3:0] cnt;
  logic [7:0] sh, data_q, status_q;
  logic flag_q, aen_q, stop_q, last_q, arb_q, ack_q, mack_q, scl_q;

  wire ctrl_wr = wr_en & wr_sel;
  wire data_wr = wr_en & ~wr_sel;
  wire clr = ctrl_wr & wr_data[0] & flag_q;
  wire mid = (st == S_ADDR && cnt != 4'd0) || st == S_AACK || st == S_TX || st == S_MACK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      data_q <= '0;
      status_q <= C_NONE;
      flag_q <= 1'b0;
      aen_q <= 1'b0;
      stop_q <= 1'b0;
      last_q <= 1'b0;
      arb_q <= 1'b0;
      ack_q <= 1'b0;
      mack_q <= 1'b0;
      scl_q <= 1'b0;
    end else begin
      scl_q <= flag_q;
      if (arb_lost) arb_q <= 1'b1;
      if (data_wr && flag_q) data_q <= wr_data;
      if (ctrl_wr) begin
        aen_q <= wr_data[1];
        stop_q <= wr_data[2];
      end
      if (clr) begin
        flag_q <= 1'b0;
        if (st == S_BERR && wr_data[2]) begin
          st <= S_IDLE;
          stop_q <= 1'b0;
        end else if (st == S_WAIT) begin
          st <= S_TX;
          sh <= data_q;
          cnt <= '0;
          last_q <= ~wr_data[1];
        end
      end else if ((start_c || stop_c) && mid) begin
        st <= S_BERR;
        flag_q <= 1'b1;
        status_q <= C_BERR;
        ack_q <= 1'b0;
      end else begin
        case (st)
          S_IDLE:
            if (start_c && !flag_q) begin
              st <= S_ADDR;
              cnt <= '0;
            end
          S_ADDR:
            if (stop_c) st <= S_IDLE;
            else if (start_c) cnt <= '0;
            else if (rise) begin
              sh <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                cnt <= '0;
                st <= (sh[6:0] == own_addr && sda) ? S_AACK : S_IDLE;
              end
            end
          S_AACK:
            if (fall) begin
              if (cnt == 4'd0) begin
                ack_q <= 1'b1;
                cnt <= 4'd1;
              end else begin
                ack_q <= 1'b0;
                flag_q <= 1'b1;
                status_q <= arb_q ? C_ADDR_ARB : C_ADDR;
                arb_q <= 1'b0;
                st <= S_WAIT;
              end
            end
          S_TX:
            if (rise) cnt <= cnt + 4'd1;
            else if (fall && cnt != 4'd0) begin
              if (cnt == 4'd8) st <= S_MACK;
              else sh <= {sh[6:0], 1'b0};
            end
          S_MACK:
            if (rise) begin
              cnt <= 4'd9;
              mack_q <= ~sda;
            end else if (fall && cnt == 4'd9) begin
              flag_q <= 1'b1;
              cnt <= '0;
              if (!mack_q) begin
                status_q <= C_NACKED;
                st <= S_IDLE;
              end else if (last_q) begin
                status_q <= C_FINAL;
                st <= S_IDLE;
              end else begin
                status_q <= C_ACKED;
                st <= S_WAIT;
              end
            end
          default: ;
        endcase
      end
    end

  assign sda_oe = (st == S_TX) ? ~sh[7] : ack_q;
  assign scl_oe = scl_q;
  assign status_o = flag_q ? status_q : C_NONE;
  assign flag_o = flag_q;
  assign ack_en_o = aen_q;
  assign stop_o = stop_q;

endmodule

// File: rtl/i2c_slave_tx_chk.sv
module i2c_slave_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_o,
  input logic [7:0] status_o,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic       stop_o
);

  assert_hold_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && $past(flag_o) |-> scl_oe);

  assert_free_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |=> !scl_oe);

  assert_legal_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> (status_o == 8'hA8 || status_o == 8'hB0 || status_o == 8'hB8 ||
                       status_o == 8'hC0 || status_o == 8'hC8 || status_o == 8'h00));

  assert_berr_sda_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && status_o == 8'h00 |-> !sda_oe);

  assert_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && status_o == 8'h00 && wr_en && wr_sel && wr_data[0] && wr_data[2]
    |=> !stop_o && !flag_o);

  assert_zero_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && wr_en && wr_sel && !wr_data[0] |=> flag_o);

endmodule

bind i2c_slave_tx i2c_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_o(flag_o), .status_o(status_o),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .stop_o(stop_o)
);

// File: tb/sim_i2c_slave_tx.sv
module sim_i2c_slave_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic arb_lost = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic scl_oe, sda_oe, flag_o, ack_en_o, stop_o;
  logic [7:0] status_o;
  logic scl_bus, sda_bus;
  int tests = 0, fails = 0;
  logic b;
  logic [7:0] rb;

  always #2 clk = ~clk;
  assign scl_bus = !(m_scl_low | scl_oe);
  assign sda_bus = !(m_sda_low | sda_oe);

  i2c_slave_tx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(7'h2A), .arb_lost(arb_lost),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .status_o(status_o),
    .flag_o(flag_o), .ack_en_o(ack_en_o), .stop_o(stop_o)
  );

  // fields: addr[34:28] rw[27] arb[26] aen[25] mack[24] data[23:16] st_a[15:8] st_d[7:0]
  localparam int NV = 7;
  localparam logic [34:0] VEC [NV] = '{
    {7'h2A, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5C, 8'hA8, 8'hB8},
    {7'h2A, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA3, 8'hA8, 8'hC0},
    {7'h2A, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 8'hA8, 8'hC8},
    {7'h2A, 1'b1, 1'b1, 1'b1, 1'b1, 8'h96, 8'hB0, 8'hB8},
    {7'h2B, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'hF8, 8'h00},
    {7'h2A, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hF8, 8'h00},
    {7'h2A, 1'b1, 1'b0, 1'b0, 1'b0, 8'hE1, 8'hA8, 8'hC0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high;
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic host_wr(input logic sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic m_start;
    m_sda_low = 1'b0; m_scl_low = 1'b0; wait_high; wt(8);
    m_sda_low = 1'b1; wt(8);
    m_scl_low = 1'b1; wt(8);
  endtask

  task automatic m_stop;
    m_sda_low = 1'b1; wt(4);
    m_scl_low = 1'b0; wait_high; wt(8);
    m_sda_low = 1'b0; wt(8);
  endtask

  task automatic m_wbit(input logic v);
    m_sda_low = !v; wt(4);
    m_scl_low = 1'b0; wait_high; wt(8);
    m_scl_low = 1'b1; wt(4);
  endtask

  task automatic m_rbit(output logic v);
    m_sda_low = 1'b0; wt(4);
    m_scl_low = 1'b0; wait_high; wt(4);
    v = sda_bus; wt(4);
    m_scl_low = 1'b1; wt(4);
  endtask

  task automatic m_wbyte(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
  endtask

  task automatic m_rbyte(output logic [7:0] d);
    logic v;
    for (int i = 0; i < 8; i++) begin
      m_rbit(v);
      d = {d[6:0], v};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wt(4); rst_n = 1'b1; wt(2);
    chk("R6 reset status", status_o, 8'hF8);
    chk("R6 reset flag", flag_o, 0);
    chk("R10 reset scl", scl_oe, 0);
    chk("R8 reset sda", sda_oe, 0);
    chk("R9 reset stop", stop_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [34:0] v;
      v = VEC[i];
      if (v[26]) begin arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0; end
      m_start;
      m_wbyte(v[34:27]);
      m_rbit(b);
      wt(4);
      if (v[15:8] == 8'hF8) begin
        chk("R7 no ack", b, 1);
        chk("R7 flag", flag_o, 0);
        chk("R6 idle status", status_o, 8'hF8);
        m_stop;
      end else begin
        chk(v[26] ? "R2 ack" : "R1 ack", b, 0);
        chk(v[26] ? "R2 status" : "R1 status", status_o, {24'd0, v[15:8]});
        chk("R10 stretch", scl_oe, 1);
        host_wr(1'b0, v[23:16]);
        host_wr(1'b1, {6'd0, v[25], 1'b1});
        m_rbyte(rb);
        chk("R3 data", rb, {24'd0, v[23:16]});
        m_wbit(!v[24]);
        wt(4);
        chk("R3 R4 R5 status", status_o, {24'd0, v[7:0]});
        chk("R6 low bits", status_o[2:0], 0);
        if (v[7:0] == 8'hB8) begin
          host_wr(1'b0, ~v[23:16]);
          host_wr(1'b1, 8'b011);
          m_rbyte(rb);
          chk("R3 second byte", rb, {24'd0, ~v[23:16]});
          m_wbit(1'b1);
          wt(4);
          chk("R4 status", status_o, 8'hC0);
        end
        host_wr(1'b1, 8'b011);
        wt(2);
        chk("R4 sda released", sda_oe, 0);
        if (v[7:0] == 8'hC8) begin
          m_rbyte(rb);
          chk("R5 ones", rb, 8'hFF);
          m_wbit(1'b1);
          wt(4);
          chk("R5 no flag", flag_o, 0);
        end
        m_stop;
      end
    end

    // R11 ignored data write, zero write to flag, R10 release timing
    host_wr(1'b0, 8'h11);
    m_start; m_wbyte({7'h2A, 1'b1}); m_rbit(b); wt(4);
    chk("R1 status", status_o, 8'hA8);
    host_wr(1'b1, 8'b010);
    chk("R11 zero write keeps flag", flag_o, 1);
    wt(2);
    chk("R10 still stretched", scl_oe, 1);
    host_wr(1'b1, 8'b011);
    chk("R11 flag cleared", flag_o, 0);
    chk("R10 one cycle lag", scl_oe, 1);
    wt(1);
    chk("R10 released", scl_oe, 0);
    m_rbyte(rb);
    chk("R11 data write ignored", rb, 8'hE1);
    m_wbit(1'b1); wt(4);
    chk("R4 status", status_o, 8'hC0);
    host_wr(1'b1, 8'b011);
    m_stop;

    // R8 illegal START in address byte, R9 recovery
    m_start; m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b0);
    m_sda_low = 1'b0; wt(4);
    m_scl_low = 1'b0; wait_high; wt(8);
    m_sda_low = 1'b1; wt(8);
    chk("R8 flag", flag_o, 1);
    chk("R8 status", status_o, 8'h00);
    chk("R8 sda", sda_oe, 0);
    host_wr(1'b1, 8'b111);
    wt(2);
    chk("R9 stop cleared", stop_o, 0);
    chk("R9 flag", flag_o, 0);
    chk("R9 ack_en kept", ack_en_o, 1);
    chk("R9 scl free", scl_oe, 0);
    chk("R9 sda free", sda_oe, 0);
    m_stop;

    // R8 STOP inside data byte, R9 recovery then normal transfer
    m_start; m_wbyte({7'h2A, 1'b1}); m_rbit(b); wt(4);
    host_wr(1'b0, 8'hFF);
    host_wr(1'b1, 8'b011);
    m_rbit(b); m_rbit(b); m_rbit(b);
    m_sda_low = 1'b1; wt(4);
    m_scl_low = 1'b0; wait_high; wt(8);
    m_sda_low = 1'b0; wt(8);
    chk("R8 data stop status", status_o, 8'h00);
    chk("R8 data stop flag", flag_o, 1);
    host_wr(1'b1, 8'b101);
    wt(2);
    chk("R9 stop cleared", stop_o, 0);
    chk("R9 ack_en written", ack_en_o, 0);
    chk("R9 released", {scl_oe, sda_oe}, 0);
    m_start; m_wbyte({7'h2A, 1'b1}); m_rbit(b); wt(4);
    chk("R9 ack after recovery", b, 0);
    chk("R9 status after recovery", status_o, 8'hA8);
    host_wr(1'b0, 8'h69);
    host_wr(1'b1, 8'b011);
    m_rbyte(rb);
    chk("R9 data after recovery", rb, 8'h69);
    m_wbit(1'b1); wt(4);
    chk("R4 status", status_o, 8'hC0);
    host_wr(1'b1, 8'b011);
    m_stop;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule